// File: doc/BRIEF.md
# Packed Float-to-Integer Truncating Converter

This block turns a vector of packed IEEE floating-point values into signed integers of the same width, with one register stage. A single format select applies to the whole vector. In single-precision mode each 32-bit word carries one binary32 value and yields one signed 32-bit integer. In half-precision mode each 32-bit word carries two binary16 values, and each becomes its own signed 16-bit integer in the same half of the word.

Any fractional part is dropped, so rounding is toward zero. Results that do not fit saturate to the end of the integer range that matches the sign of the input. NaN inputs also saturate, and only their sign bit decides the direction: it does not matter whether the NaN is quiet or signalling. Anything with magnitude below one gives zero. An input valid strobe captures the converted vector, and the output valid strobe follows it one clock later.

Top module: `ftoi_conv`

## Requirements
- R1: With `in_fmt`=0, each 32-bit word is a binary32 value (sign bit 31, exponent bits 30:23, fraction bits 22:0). It converts to a signed 32-bit two's-complement integer in the same word position.
- R2: With `in_fmt`=1, bits 15:0 and bits 31:16 of each word are separate binary16 values (sign bit 15, exponent bits 14:10, fraction bits 9:0). Each converts to a signed 16-bit integer in the same half, and neither half affects the other.
- R3: The fractional part is discarded toward zero for both signs. For example, -2.75 gives -2 and 2.5 gives 2.
- R4: A NaN with its sign bit clear gives the largest positive integer of the lane width, 0x7FFFFFFF or 0x7FFF, whether the NaN is quiet or signalling.
- R5: A NaN with its sign bit set gives the most negative integer of the lane width, 0x80000000 or 0x8000, whether the NaN is quiet or signalling.
- R6: Positive infinity and finite values of 2^(W-1) or more give the positive maximum. Negative infinity and values below -2^(W-1) give the negative minimum. Exactly -2^(W-1) gives the negative minimum.
- R7: Zero, negative zero, subnormals and every magnitude below 1.0 give 0.
- R8: `out_valid` equals `in_valid` from the previous clock. A synchronous reset clears `out_valid` and `out_data` to zero.
- R9: `out_data` is loaded only in a cycle with `in_valid` high. Otherwise it keeps its previous value whatever `in_data` and `in_fmt` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_fmt | input | 1 | Lane format: 0 = binary32, 1 = two binary16 per word |
| in_data | input | NUM_WORDS*32 | Packed floating-point input vector |
| out_valid | output | 1 | Output vector valid, one clock after `in_valid` |
| out_data | output | NUM_WORDS*32 | Packed signed integer results |

## Verification
Two functions can fall in the same cycle. In one half-precision word, one half can saturate because it is a NaN or infinity while the other half is truncated normally. Also, the format can change between two back-to-back valid cycles. The bench drives words whose low half is a negative NaN and whose high half is an ordinary value, or the reverse. It alternates `in_fmt` on consecutive strobes. It then compares every 16-bit and 32-bit field with a reference that decodes the values as real numbers. Any bleeding between halves or any stale format choice appears as a field mismatch.

// File: rtl/ftoi_pkg.sv
package ftoi_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int SP_EXP  = 8;
    localparam int SP_MAN  = 23;
    localparam int HP_EXP  = 5;
    localparam int HP_MAN  = 10;
    localparam int HALVES  = WORD_W / HALF_W;

    typedef enum logic {
        FMT_SP = 1'b0,
        FMT_HP = 1'b1
    } lane_fmt_e;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_SAT  = 2'd1,
        CLS_NUM  = 2'd2
    } lane_cls_e;

    typedef struct packed {
        logic      valid;
        lane_fmt_e fmt;
    } ctrl_t;

endpackage

// File: rtl/ftoi_lane.sv
module ftoi_lane
    import ftoi_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32
) (
    input  logic [EXP_W+MAN_W:0] fp_i,
    output logic [INT_W-1:0]     int_o
);

    localparam int FP_W  = EXP_W + MAN_W + 1;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int SH_W  = INT_W + MAN_W;
    localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] OVF_V  = EXP_W'(BIAS + INT_W - 1);
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};

    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [MAN_W-1:0]  frac;
    logic [EXP_W-1:0]  ushift;
    logic [SH_W-1:0]   shifted;
    logic [INT_W-1:0]  mag;
    lane_cls_e         cls;

    assign sgn  = fp_i[FP_W-1];
    assign expo = fp_i[MAN_W +: EXP_W];
    assign frac = fp_i[MAN_W-1:0];

    // Classify: all-ones exponent (NaN or infinity) and out-of-range saturate
    always_comb begin
        if (expo == {EXP_W{1'b1}}) begin
            cls = CLS_SAT;
        end else if (expo < BIAS_V) begin
            cls = CLS_ZERO;
        end else if (expo >= OVF_V) begin
            cls = CLS_SAT;
        end else begin
            cls = CLS_NUM;
        end
    end

    // Integer part: place the hidden one, shift by unbiased exponent, drop fraction
    assign ushift  = expo - BIAS_V;
    assign shifted = {{(SH_W-MAN_W-1){1'b0}}, 1'b1, frac} << ushift;
    assign mag     = INT_W'(shifted >> MAN_W);

    always_comb begin
        unique case (cls)
            CLS_SAT:  int_o = sgn ? NEG_MIN : POS_MAX;
            CLS_NUM:  int_o = sgn ? (~mag + INT_W'(1)) : mag;
            default:  int_o = '0;
        endcase
    end

endmodule

// File: rtl/ftoi_word.sv
module ftoi_word
    import ftoi_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  lane_fmt_e         fmt_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] sp_res;
    logic [WORD_W-1:0] hp_res;

    ftoi_lane #(
        .EXP_W (SP_EXP),
        .MAN_W (SP_MAN),
        .INT_W (WORD_W)
    ) u_sp (
        .fp_i  (word_i),
        .int_o (sp_res)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ftoi_lane #(
            .EXP_W (HP_EXP),
            .MAN_W (HP_MAN),
            .INT_W (HALF_W)
        ) u_hp (
            .fp_i  (word_i[h*HALF_W +: HALF_W]),
            .int_o (hp_res[h*HALF_W +: HALF_W])
        );
    end

    assign word_o = (fmt_i == FMT_HP) ? hp_res : sp_res;

endmodule

// File: rtl/ftoi_conv.sv
module ftoi_conv
    import ftoi_pkg::*;
#(
    parameter int NUM_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic                        in_fmt,
    input  logic [NUM_WORDS*WORD_W-1:0] in_data,
    output logic                        out_valid,
    output logic [NUM_WORDS*WORD_W-1:0] out_data
);

    localparam int VEC_W = NUM_WORDS * WORD_W;

    ctrl_t            ctrl;
    logic [VEC_W-1:0] conv;

    assign ctrl.valid = in_valid;
    assign ctrl.fmt   = lane_fmt_e'(in_fmt);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        ftoi_word u_word (
            .word_i (in_data[w*WORD_W +: WORD_W]),
            .fmt_i  (ctrl.fmt),
            .word_o (conv[w*WORD_W +: WORD_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctrl.valid;
            if (ctrl.valid) begin
                out_data <= conv;
            end
        end
    end

endmodule

// File: rtl/ftoi_conv_chk.sv
module ftoi_conv_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_fmt,
    input logic [31:0] lo_in,
    input logic        out_valid,
    input logic [31:0] lo_out
);

    // R8: output strobe follows input strobe by one clock
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: no capture without a strobe
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(lo_out));

    // R4: positive NaN, binary32 lane
    p_nan_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_fmt && !lo_in[31] && lo_in[30:23] == 8'hFF && lo_in[22:0] != 23'd0)
        |=> lo_out == 32'h7FFF_FFFF);

    // R5: negative NaN, binary32 lane
    p_nan_neg_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_fmt && lo_in[31] && lo_in[30:23] == 8'hFF && lo_in[22:0] != 23'd0)
        |=> lo_out == 32'h8000_0000);

    // R6: positive infinity or NaN in the low binary16 lane saturates high
    p_half_sat_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_fmt && !lo_in[15] && lo_in[14:10] == 5'h1F)
        |=> lo_out[15:0] == 16'h7FFF);

    // R7: magnitude below one gives zero, binary32 lane
    p_tiny_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_fmt && lo_in[30:23] < 8'd127)
        |=> lo_out == 32'd0);

endmodule

bind ftoi_conv ftoi_conv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_fmt    (in_fmt),
    .lo_in     (in_data[31:0]),
    .out_valid (out_valid),
    .lo_out    (out_data[31:0])
);

// File: tb/ftoi_conv_bench.sv
module ftoi_conv_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 4;
    localparam int VW         = NW * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_fmt = 1'b0;
    logic [VW-1:0] in_data = '0;
    logic          out_valid;
    logic [VW-1:0] out_data;

    int            checks = 0;
    int            errors = 0;
    logic          exp_valid = 1'b0;
    logic [VW-1:0] exp_data = '0;

    ftoi_conv #(.NUM_WORDS(NW)) u_ftoi_conv (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_fmt    (in_fmt),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic real pow2(int k);
        real r = 1.0;
        if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
        else        for (int i = 0; i < -k; i++) r = r / 2.0;
        return r;
    endfunction

    // Decode the float as a real number and truncate; saturate by sign
    function automatic logic [31:0] ref_lane(logic [31:0] bits, int eb, int mb, int iw);
        int         sgn  = int'(bits[eb+mb]);
        int         e    = int'(bits >> mb) & ((1 << eb) - 1);
        int         m    = int'(bits) & ((1 << mb) - 1);
        int         bias = (1 << (eb - 1)) - 1;
        longint     maxv = (longint'(1) << (iw - 1)) - 1;
        longint     minv = -(longint'(1) << (iw - 1));
        longint     res;
        real        val;
        real        lim  = pow2(iw - 1);
        logic [63:0] r64;
        if (e == (1 << eb) - 1) begin
            res = (sgn != 0) ? minv : maxv;
        end else begin
            if (e == 0) val = real'(m) * pow2(1 - bias - mb);
            else        val = real'(m + (1 << mb)) * pow2(e - bias - mb);
            if (sgn != 0) val = -val;
            if (val >= lim)       res = maxv;
            else if (val < -lim)  res = minv;
            else                  res = longint'($rtoi(val));
        end
        r64 = 64'(res);
        return (iw == 32) ? r64[31:0] : {16'h0, r64[15:0]};
    endfunction

    function automatic logic [VW-1:0] ref_vec(logic [VW-1:0] d, logic f);
        logic [VW-1:0] o;
        for (int w = 0; w < NW; w++) begin
            logic [31:0] wd = d[w*32 +: 32];
            logic [31:0] lo = ref_lane({16'h0, wd[15:0]}, 5, 10, 16);
            logic [31:0] hi = ref_lane({16'h0, wd[31:16]}, 5, 10, 16);
            o[w*32 +: 32] = f ? {hi[15:0], lo[15:0]} : ref_lane(wd, 8, 23, 32);
        end
        return o;
    endfunction

    function automatic logic [VW-1:0] pk(logic [31:0] a, logic [31:0] b,
                                          logic [31:0] c, logic [31:0] d);
        return {d, c, b, a};
    endfunction

    task automatic compare(string tag);
        checks++;
        if (out_valid !== exp_valid) begin
            errors++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", tag, out_valid, exp_valid);
        end
        checks++;
        if (out_data !== exp_data) begin
            errors++;
            $display("FAIL %s out_data actual=%h expected=%h", tag, out_data, exp_data);
        end
    endtask

    // Drive at the falling edge, model updates at the rising edge, compare at next falling edge
    task automatic cycle(logic v, logic f, logic [VW-1:0] d, string tag);
        logic [VW-1:0] nxt;
        in_valid = v;
        in_fmt   = f;
        in_data  = d;
        nxt      = ref_vec(d, f);
        @(posedge clk);
        exp_valid = v;
        if (v) exp_data = nxt;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R8 reset");
        rst = 1'b0;

        // R1 R3: ordinary binary32 values, both signs
        cycle(1, 0, pk(32'h3F80_0000, 32'hC030_0000, 32'h4020_0000, 32'h47F1_2000), "R1 R3");
        cycle(1, 0, pk(32'hBFC0_0000, 32'h4EFF_FFFF, 32'hC2F6_E979, 32'h4479_FFFF), "R1 R3");
        // R4 R5: quiet and signalling NaNs of both signs
        cycle(1, 0, pk(32'h7FC0_0000, 32'h7F80_0001, 32'hFFC0_0000, 32'hFF80_0001), "R4 R5");
        // R6: infinities and out-of-range magnitudes
        cycle(1, 0, pk(32'h7F80_0000, 32'hFF80_0000, 32'h4F00_0000, 32'hCF80_0000), "R6");
        cycle(1, 0, pk(32'hCF00_0000, 32'h7F7F_FFFF, 32'hFF7F_FFFF, 32'h4F80_0000), "R6");
        // R7: zero, negative zero, subnormal, just below one
        cycle(1, 0, pk(32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h3F7F_FFFF), "R7");
        cycle(1, 0, pk(32'hBF00_0000, 32'h807F_FFFF, 32'hBF7F_FFFF, 32'h3E80_0000), "R7");
        // R9 R8: garbage without strobe must not be captured
        cycle(0, 1, pk(32'h7FC0_0000, 32'h1234_5678, 32'hFFFF_FFFF, 32'h3F80_0000), "R9 R8");
        cycle(0, 0, pk(32'h7F80_0000, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h4F00_0000), "R9 R8");
        // R2 R3: binary16 halves
        cycle(1, 1, pk(32'hC100_3C00, 32'h7400_5640, 32'hBE00_77FF, 32'h4100_C500), "R2 R3");
        // R4 R5 R6: half-precision saturation, NaN in one half and a number in the other
        cycle(1, 1, pk(32'h3C00_FE00, 32'h7C01_4500, 32'hFC00_7C00, 32'hF800_7BFF), "R2 R4 R5 R6");
        cycle(1, 1, pk(32'h7800_FC01, 32'hFE00_7E00, 32'h5640_7C00, 32'hF801_F7FF), "R2 R4 R5 R6");
        // R7: half-precision tiny values
        cycle(1, 1, pk(32'h8000_0000, 32'h3BFF_0001, 32'hB800_83FF, 32'hBBFF_3800), "R7");
        // Format switching on back-to-back strobes
        cycle(1, 0, pk(32'h3C00_4100, 32'hFE00_C100, 32'h7C00_3C00, 32'h4100_FC00), "R1 R2");
        cycle(1, 1, pk(32'h3C00_4100, 32'hFE00_C100, 32'h7C00_3C00, 32'h4100_FC00), "R1 R2");
        cycle(1, 0, pk(32'hC030_0000, 32'h7FC0_0000, 32'h4020_0000, 32'hFF80_0000), "R1 R2");

        // Mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic [VW-1:0] d;
            for (int w = 0; w < NW; w++) d[w*32 +: 32] = $urandom();
            cycle(($urandom() % 4) != 0, $urandom() % 2 == 1, d, "R1 R2 R8 R9 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule